// File: doc/BRIEF.md
# Multi-Channel Triggered Delay and Gate Generator

This block provides eight independent pulse channels running from one system clock. Each channel watches an asynchronous trigger line. The line is first brought into the clock domain through a short synchronizer chain. Its rising edge is then found by comparing the synchronized level with a registered copy of itself. No flip-flop is ever clocked by a trigger.

When an idle channel sees a rising edge, it accepts the trigger and latches its programmed delay and gate length. It then counts the delay and drives its output high for exactly the gate length. While it is doing this the channel is busy, and every further edge on its trigger is dropped. When the gate ends, the counter clears and the channel is ready again.

Delay and gate lengths are 32-bit unsigned cycle counts, written through a plain address/data/strobe port. The end point of the whole sequence is held at 33 bits, so the largest delay plus the largest gate never wraps.

Top module: `dg_multi`

## Requirements
- R1: After reset, every gate output is low and every stored delay and gate length is zero. A trigger on a channel that has not been programmed therefore produces no pulse.
- R2: Write addresses select the setting. Address 2n holds the delay of channel n and address 2n+1 holds its gate length. A value is stored when `wr_en` is high on a clock edge.
- R3: A trigger input sampled high at clock edge k, after being low, makes the output rise after edge k+2+D. Here D is the delay latched at acceptance.
- R4: Once risen, the output stays high for exactly G clock cycles, where G is the latched gate length, and then falls.
- R5: From acceptance until the gate ends, further rising edges on that channel's trigger are ignored. This holds during the delay phase and during the gate phase.
- R6: A gate length of zero produces no pulse. The channel still returns to idle once the delay has elapsed, and it accepts the next trigger.
- R7: A delay of zero makes the output rise on the first cycle after the trigger edge is detected, which is after edge k+2 in the terms of R3.
- R8: A write to a busy channel does not alter the pulse in progress. The new value applies from the next accepted trigger, including a write landing on the acceptance edge itself.
- R9: Channels are independent. Simultaneous triggers with different settings each give their own correctly timed pulse.
- R10: A trigger held high for many cycles counts as one edge and gives one pulse.
- R11: The delay plus gate end point is computed without overflow. A 32-bit all-ones gate length after a short delay keeps the output high, rather than ending the pulse early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the settings |
| wr_addr | input | 4 | Setting address: 2n delay, 2n+1 gate of channel n |
| wr_data | input | 32 | Value to write |
| trig_i | input | 8 | Asynchronous trigger lines, one per channel |
| gate_o | output | 8 | Registered gate outputs, one per channel |

## Verification
The hardest situation to create from the ports is a new trigger edge landing inside a busy window, in both the delay phase and the gate phase. The stimulus fires one-cycle trigger pulses at sample points chosen so that, after the synchronizer latency, the edge is detected while the channel is still counting. The output must then show exactly one pulse.

A second awkward case is a write arriving on the very edge on which a trigger is accepted. The stimulus schedules the write to land on that acceptance edge, and then checks that the old length is used and that the new length shows up on the following trigger.

The no-overflow end point cannot be run to completion. It is instead shown by a short delay with an all-ones gate, whose output must stay high across the whole observation window.

// File: rtl/dg_pkg.sv
package dg_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_RUN  = 1'b1
  } ch_state_e;
endpackage

// File: rtl/dg_trig_edge.sv
module dg_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain_q[STAGES-1];
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dg_cfg_regs.sv
module dg_cfg_regs #(
  parameter int NCH = 8,
  parameter int CW  = 32,
  localparam int AW = $clog2(2 * NCH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [CW-1:0]           wr_data,
  output logic [NCH-1:0][CW-1:0]  dly_o,
  output logic [NCH-1:0][CW-1:0]  len_o
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [AW-1:0] A_DLY = AW'(2 * n);
      localparam logic [AW-1:0] A_LEN = AW'(2 * n + 1);

      always_ff @(posedge clk) begin
        if (rst) begin
          dly_o[n] <= '0;
          len_o[n] <= '0;
        end else if (wr_en) begin
          if (wr_addr == A_DLY) dly_o[n] <= wr_data;
          if (wr_addr == A_LEN) len_o[n] <= wr_data;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/dg_channel.sv
module dg_channel
  import dg_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_i,
  input  logic [CW-1:0] dly_i,
  input  logic [CW-1:0] len_i,
  output logic          gate_o,
  output logic          busy_o
);
  ch_state_e   state_q;
  logic [CW:0] cnt_q;
  logic [CW:0] dly_q;
  logic [CW:0] stop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
      dly_q   <= '0;
      stop_q  <= '0;
      gate_o  <= 1'b0;
    end else begin
      case (state_q)
        CH_IDLE: begin
          if (fire_i) begin
            state_q <= CH_RUN;
            dly_q   <= {1'b0, dly_i};
            stop_q  <= {1'b0, dly_i} + {1'b0, len_i};
            cnt_q   <= (CW+1)'(1);
            gate_o  <= (dly_i == '0) && (len_i != '0);
          end
        end
        default: begin
          if (cnt_q >= stop_q) begin
            state_q <= CH_IDLE;
            cnt_q   <= '0;
            gate_o  <= 1'b0;
          end else begin
            cnt_q   <= cnt_q + (CW+1)'(1);
            gate_o  <= (cnt_q >= dly_q);
          end
        end
      endcase
    end
  end

  assign busy_o = (state_q == CH_RUN);
endmodule

// File: rtl/dg_multi.sv
module dg_multi #(
  parameter int NCH         = 8,
  parameter int CW          = 32,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(2 * NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [CW-1:0]  wr_data,
  input  logic [NCH-1:0] trig_i,
  output logic [NCH-1:0] gate_o
);
  logic [NCH-1:0][CW-1:0] dly_w;
  logic [NCH-1:0][CW-1:0] len_w;
  logic [NCH-1:0]         rise_w;
  logic [NCH-1:0]         busy_w;

  dg_cfg_regs #(.NCH(NCH), .CW(CW)) i_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .dly_o  (dly_w),
    .len_o  (len_w)
  );

  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      dg_trig_edge #(.STAGES(SYNC_STAGES)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .async_i(trig_i[n]),
        .rise_o (rise_w[n])
      );

      dg_channel #(.CW(CW)) i_chan (
        .clk   (clk),
        .rst   (rst),
        .fire_i(rise_w[n]),
        .dly_i (dly_w[n]),
        .len_i (len_w[n]),
        .gate_o(gate_o[n]),
        .busy_o(busy_w[n])
      );
    end
  endgenerate
endmodule

// File: rtl/dg_multi_chk.sv
module dg_multi_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] gate_o,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] rise
);
  generate
    for (genvar n = 0; n < NCH; n++) begin : g_ch
      a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (gate_o[n] == 1'b0 && busy[n] == 1'b0));

      a_r5_gate_inside_busy: assert property (@(posedge clk) disable iff (rst)
        gate_o[n] |-> busy[n]);

      a_r3_edge_accepted: assert property (@(posedge clk) disable iff (rst)
        (rise[n] && !busy[n]) |=> busy[n]);

      a_r10_single_edge: assert property (@(posedge clk) disable iff (rst)
        rise[n] |=> !rise[n]);

      a_r4_fall_ends_busy: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_o[n]) |-> $fell(busy[n]));
    end
  endgenerate
endmodule

bind dg_multi dg_multi_chk #(.NCH(NCH)) i_dg_multi_chk (
  .clk   (clk),
  .rst   (rst),
  .gate_o(gate_o),
  .busy  (busy_w),
  .rise  (rise_w)
);

// File: tb/test_dg_multi.sv
module test_dg_multi;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  trig_i = '0;
  logic [7:0]  gate_o;

  int checks = 0;
  int errors = 0;

  int first_hi [NCH];
  int cnt_hi   [NCH];
  int rises    [NCH];

  int          ra = -1;
  int          rb = -1;
  int          wat = -1;
  logic [3:0]  wa = '0;
  logic [31:0] wd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dg_multi i_dg_multi (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .trig_i (trig_i),
    .gate_o (gate_o)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    trig_i = '0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Raise triggers in mask, record outputs for win samples; trigger drops after hold.
  task automatic observe(input logic [7:0] mask, input int win, input int hold);
    logic [7:0] prev;
    for (int c = 0; c < NCH; c++) begin
      first_hi[c] = -1;
      cnt_hi[c] = 0;
      rises[c] = 0;
    end
    prev = gate_o;
    @(negedge clk);
    trig_i = trig_i | mask;
    for (int n = 1; n <= win; n++) begin
      @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        if (gate_o[c]) begin
          cnt_hi[c]++;
          if (first_hi[c] < 0) first_hi[c] = n;
          if (!prev[c]) rises[c]++;
        end
      end
      prev = gate_o;
      if (n == hold) trig_i = trig_i & ~mask;
      if (n == ra || n == rb) trig_i = trig_i | mask;
      if (n == ra + 1 || n == rb + 1) trig_i = trig_i & ~mask;
      if (n == wat) begin
        wr_en = 1'b1;
        wr_addr = wa;
        wr_data = wd;
      end
      if (n == wat + 1) wr_en = 1'b0;
    end
    trig_i = trig_i & ~mask;
    ra = -1;
    rb = -1;
    wat = -1;
  endtask

  task automatic t_reset();
    chk(gate_o == 8'h00, "R1 outputs low after reset", gate_o, 0);
    observe(8'h01, 15, 2);
    chk(cnt_hi[0] == 0, "R1 unprogrammed channel gives no pulse", cnt_hi[0], 0);
  endtask

  task automatic t_basic();
    wr(4'd0, 32'd4);
    wr(4'd1, 32'd3);
    observe(8'h01, 20, 2);
    chk(first_hi[0] == 7, "R3 rise after edge k+2+D", first_hi[0], 7);
    chk(cnt_hi[0] == 3, "R4 gate length", cnt_hi[0], 3);
    chk(rises[0] == 1, "R2 delay/gate address map single pulse", rises[0], 1);
  endtask

  task automatic t_zero_delay();
    wr(4'd3, 32'd5);
    wr(4'd2, 32'd0);
    observe(8'h02, 15, 2);
    chk(first_hi[1] == 3, "R7 zero delay rise", first_hi[1], 3);
    chk(cnt_hi[1] == 5, "R7 zero delay gate length", cnt_hi[1], 5);
  endtask

  task automatic t_zero_gate();
    wr(4'd4, 32'd3);
    wr(4'd5, 32'd0);
    observe(8'h04, 15, 2);
    chk(cnt_hi[2] == 0, "R6 zero gate no pulse", cnt_hi[2], 0);
    wr(4'd5, 32'd2);
    observe(8'h04, 15, 2);
    chk(first_hi[2] == 6, "R6 channel idle again, rise", first_hi[2], 6);
    chk(cnt_hi[2] == 2, "R6 channel idle again, length", cnt_hi[2], 2);
  endtask

  task automatic t_busy_ignore();
    wr(4'd6, 32'd5);
    wr(4'd7, 32'd5);
    ra = 5;
    rb = 9;
    observe(8'h08, 30, 2);
    chk(rises[3] == 1, "R5 retriggers ignored, pulse count", rises[3], 1);
    chk(first_hi[3] == 8, "R5 retriggers ignored, rise", first_hi[3], 8);
    chk(cnt_hi[3] == 5, "R5 retriggers ignored, length", cnt_hi[3], 5);
  endtask

  task automatic t_update_busy();
    wr(4'd8, 32'd3);
    wr(4'd9, 32'd4);
    wat = 2;
    wa = 4'd9;
    wd = 32'd10;
    observe(8'h10, 25, 2);
    chk(cnt_hi[4] == 4, "R8 write at acceptance keeps old length", cnt_hi[4], 4);
    observe(8'h10, 25, 2);
    chk(cnt_hi[4] == 10, "R8 new length on next trigger", cnt_hi[4], 10);
    chk(first_hi[4] == 6, "R8 delay unchanged", first_hi[4], 6);
  endtask

  task automatic t_independent();
    wr(4'd10, 32'd1);
    wr(4'd11, 32'd3);
    wr(4'd12, 32'd6);
    wr(4'd13, 32'd2);
    wr(4'd14, 32'd2);
    wr(4'd15, 32'd7);
    observe(8'hE0, 20, 2);
    chk(first_hi[5] == 4 && cnt_hi[5] == 3, "R9 channel 5", first_hi[5], 4);
    chk(first_hi[6] == 9 && cnt_hi[6] == 2, "R9 channel 6", first_hi[6], 9);
    chk(first_hi[7] == 5 && cnt_hi[7] == 7, "R9 channel 7", cnt_hi[7], 7);
    chk(cnt_hi[0] == 0 && cnt_hi[1] == 0, "R9 idle channels quiet", cnt_hi[0] + cnt_hi[1], 0);
  endtask

  task automatic t_level_hold();
    wr(4'd0, 32'd2);
    wr(4'd1, 32'd2);
    observe(8'h01, 40, 40);
    chk(rises[0] == 1, "R10 held level one pulse", rises[0], 1);
    chk(cnt_hi[0] == 2, "R10 held level length", cnt_hi[0], 2);
  endtask

  task automatic t_wide_sum();
    wr(4'd2, 32'd5);
    wr(4'd3, 32'hFFFF_FFFF);
    observe(8'h02, 150, 2);
    chk(first_hi[1] == 8, "R11 rise with all-ones gate", first_hi[1], 8);
    chk(cnt_hi[1] == 143, "R11 no early end", cnt_hi[1], 143);
    do_reset();
    @(negedge clk);
    chk(gate_o == 8'h00, "R1 reset ends running pulse", gate_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    t_reset();
    t_basic();
    t_zero_delay();
    t_zero_gate();
    t_busy_ignore();
    t_update_busy();
    t_independent();
    t_level_hold();
    t_wide_sum();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule